// File: doc/BRIEF.md
# Fan Tachometer Period Counter

This block measures the speed of up to eight fans by timing their tachometer signals. A fan gives two tach pulses per revolution. For the channel it is serving, the block counts ticks of a slow reference enable between the first and the third rising tach edge, which is one full revolution. The ticks first pass through a divide-by-1, 2, 4 or 8 prescaler that is chosen per channel. The 8-bit result goes into that channel's value register. The count grows as the fan slows: at a 22.5 kHz tick rate, a count of 153 is about 8800 RPM with divisor 1 and about 1100 RPM with divisor 8. Converting a count to RPM is left to software.

A single measurement engine serves the enabled channels in turn, round robin. The measurement window closes at full scale (255). A fan that is stalled or very slow therefore reads 255 and cannot hold up the other channels. Each channel has a limit input. Its out-of-limit flag goes high when the stored count is above the limit, because a larger count means a slower fan. A channel whose pin serves as a general-purpose I/O is disabled and takes no part in measurement.

Top module: `tach_period_meter`

## Requirements
- R1: While reset is asserted, and after it until a measurement completes, every count reads 0 and every out-of-limit flag reads 0.
- R2: Each tach input passes through a two-flop synchronizer and a rising-edge detector. For the channel being measured, the stored count is floor(N / D), where N is the number of cycles with ref_tick_i high strictly between the first and the third detected rising edge and D is the channel's divisor. A tick in the same cycle as the first or the third edge is not counted.
- R3: The 2-bit divisor field of channel k is div_sel_i[2k+1:2k]. The value s selects divisor 2^s: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R4: When the prescaled count reaches 255 before the third edge, the measurement ends and 255 is stored.
- R5: When no first rising edge arrives before 255 × D reference ticks have passed since the channel was selected, 255 is stored. A stalled fan with its input held at either level reads 255.
- R6: over_limit_o[k] is 1 when channel k is enabled and its count, count_o[8k+7:8k], is greater than limit_i[8k+7:8k] or equals 255. A count equal to the limit gives 0. The flag follows a change of the limit in the same cycle.
- R7: A channel whose meas_en_i bit is 0 reads count 0 and flag 0 from the next cycle on. It is skipped by the sequencer, and any measurement of it in progress is abandoned.
- R8: Enabled channels are measured one after another in ascending order, wrapping around. Each completed measurement updates only that channel's register, and the next enabled channel starts at once. A stalled channel delays the others by at most its saturation time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tach_i | input | NCH | Raw tach inputs, one bit per channel |
| ref_tick_i | input | 1 | One-cycle reference tick, nominally 22.5 kHz |
| meas_en_i | input | NCH | Per-channel measurement enable (0 means the pin serves as a GPIO) |
| div_sel_i | input | SELW*NCH | Per-channel prescale selection, divisor 2^s |
| limit_i | input | CW*NCH | Per-channel count limit |
| count_o | output | CW*NCH | Per-channel stored count |
| over_limit_o | output | NCH | Per-channel out-of-limit flag |

## Verification
Any wrong state in the shared engine shows up as a wrong value on count_o. Examples are a prescaler phase that was not cleared at the first edge, an edge counter that is off by one, or a channel pointer that skips or repeats a channel. The error appears once the affected channel finishes a measurement, which takes at most one sequencer round after the configuration settles. A missed saturation shows up differently: the engine stops advancing, so every other enabled channel keeps a stale value. The bench therefore sets tach periods and divisors whose counts it can compute exactly, and waits two worst-case rounds before reading back all eight channels.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_HALF = 2'd2,
    ST_FULL = 2'd3
  } tpm_state_e;

  function automatic int div_ratio(input int sel);
    return 1 << sel;
  endfunction

endpackage

// File: rtl/tpm_sync_edge.sv
module tpm_sync_edge #(
  parameter int NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] tach_i,
  output logic [NCH-1:0] rise_o
);

  logic [NCH-1:0] meta_q;
  logic [NCH-1:0] sync_q;
  logic [NCH-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= tach_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    // R2
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o[k] |=> !rise_o[k]);
  end

endmodule

// File: rtl/tpm_window.sv
module tpm_window
  import tpm_pkg::*;
#(
  parameter int NCH  = 8,
  parameter int CW   = 8,
  parameter int SELW = 2,
  parameter int CHW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick_i,
  input  logic [NCH-1:0]    rise_i,
  input  logic [NCH-1:0]    en_i,
  input  logic [SELW*NCH-1:0] div_sel_i,
  output logic              wr_en_o,
  output logic [CHW-1:0]    wr_ch_o,
  output logic [CW-1:0]     wr_val_o
);

  localparam int DIV_MAX = 1 << ((1 << SELW) - 1);
  localparam int PW      = (DIV_MAX > 1) ? $clog2(DIV_MAX) : 1;
  localparam logic [CW-1:0] CFULL = '1;
  localparam logic [CW-1:0] CNEAR = CFULL - CW'(1);

  tpm_state_e     state_q, state_d;
  logic [CHW-1:0] cur_q, cur_d;
  logic [CW-1:0]  cnt_q, cnt_d;
  logic [PW-1:0]  pre_q, pre_d;

  logic [CHW-1:0]  nxt_ch;
  logic            any_en;
  logic            cur_en;
  logic            cur_rise;
  logic [SELW-1:0] cur_sel;
  logic [PW-1:0]   div_m1;
  logic            step;
  logic            sat_hit;
  logic            adv;

  assign any_en   = |en_i;
  assign cur_en   = en_i[cur_q];
  assign cur_rise = rise_i[cur_q];
  assign cur_sel  = div_sel_i[cur_q*SELW +: SELW];
  assign div_m1   = PW'(div_ratio(int'(cur_sel)) - 1);
  assign step     = ref_tick_i && (pre_q == div_m1);
  assign sat_hit  = step && (cnt_q == CNEAR);

  // next enabled channel after the current one, wrapping
  always_comb begin
    logic found;
    found  = 1'b0;
    nxt_ch = cur_q;
    for (int i = 1; i <= NCH; i++) begin
      if (!found && en_i[(int'(cur_q) + i) % NCH]) begin
        found  = 1'b1;
        nxt_ch = CHW'((int'(cur_q) + i) % NCH);
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    cur_d    = cur_q;
    cnt_d    = cnt_q;
    pre_d    = pre_q;
    wr_en_o  = 1'b0;
    wr_val_o = cnt_q;
    adv      = 1'b0;

    if (state_q == ST_IDLE) begin
      adv = any_en;
    end else if (!cur_en) begin
      adv = 1'b1;
    end else if (cur_rise && state_q == ST_ARM) begin
      state_d = ST_HALF;
      cnt_d   = '0;
      pre_d   = '0;
    end else if (cur_rise && state_q == ST_FULL) begin
      wr_en_o  = 1'b1;
      wr_val_o = cnt_q;
      adv      = 1'b1;
    end else if (sat_hit) begin
      wr_en_o  = 1'b1;
      wr_val_o = CFULL;
      adv      = 1'b1;
    end else begin
      if (cur_rise) state_d = ST_FULL;
      if (ref_tick_i) begin
        if (step) begin
          pre_d = '0;
          cnt_d = cnt_q + CW'(1);
        end else begin
          pre_d = pre_q + PW'(1);
        end
      end
    end

    if (adv) begin
      if (any_en) begin
        cur_d   = nxt_ch;
        state_d = ST_ARM;
        cnt_d   = '0;
        pre_d   = '0;
      end else begin
        state_d = ST_IDLE;
      end
    end
  end

  assign wr_ch_o = cur_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cur_q   <= CHW'(NCH - 1);
      cnt_q   <= '0;
      pre_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      cnt_q   <= cnt_d;
      pre_q   <= pre_d;
    end
  end

  // R7
  wr_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> en_i[wr_ch_o]);

  // R8
  restart_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (state_q == ST_ARM && cnt_q == '0));

  // R2
  third_edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FULL && en_i[cur_q] && rise_i[cur_q]) |-> wr_en_o);

  // R4
  count_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FULL && en_i[cur_q] && !rise_i[cur_q] && !wr_en_o)
      |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/tpm_value_bank.sv
module tpm_value_bank #(
  parameter int NCH = 8,
  parameter int CW  = 8,
  parameter int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    en_i,
  input  logic              wr_en_i,
  input  logic [CHW-1:0]    wr_ch_i,
  input  logic [CW-1:0]     wr_val_i,
  input  logic [CW*NCH-1:0] limit_i,
  output logic [CW*NCH-1:0] count_o,
  output logic [NCH-1:0]    over_o
);

  localparam logic [CW-1:0] CFULL = '1;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [CW-1:0] val_q, val_d;
    logic          hit;

    assign hit = wr_en_i && (wr_ch_i == CHW'(k));

    always_comb begin
      if (!en_i[k])  val_d = '0;
      else if (hit)  val_d = wr_val_i;
      else           val_d = val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign count_o[k*CW +: CW] = val_q;
    assign over_o[k] = en_i[k] &&
                       ((val_q > limit_i[k*CW +: CW]) || (val_q == CFULL));

    // R7
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i[k] |=> (count_o[k*CW +: CW] == '0));

    // R8
    value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[k] && !hit) |=> (count_o[k*CW +: CW] == $past(count_o[k*CW +: CW])));

    // R5
    stall_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[k] && count_o[k*CW +: CW] == CFULL) |-> over_o[k]);
  end

endmodule

// File: rtl/tach_period_meter.sv
module tach_period_meter #(
  parameter int NCH  = 8,
  parameter int CW   = 8,
  parameter int SELW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      tach_i,
  input  logic                ref_tick_i,
  input  logic [NCH-1:0]      meas_en_i,
  input  logic [SELW*NCH-1:0] div_sel_i,
  input  logic [CW*NCH-1:0]   limit_i,
  output logic [CW*NCH-1:0]   count_o,
  output logic [NCH-1:0]      over_limit_o
);

  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [NCH-1:0] rise;
  logic           wr_en;
  logic [CHW-1:0] wr_ch;
  logic [CW-1:0]  wr_val;

  tpm_sync_edge #(.NCH(NCH)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .tach_i (tach_i),
    .rise_o (rise)
  );

  tpm_window #(.NCH(NCH), .CW(CW), .SELW(SELW), .CHW(CHW)) u_window (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_tick_i (ref_tick_i),
    .rise_i     (rise),
    .en_i       (meas_en_i),
    .div_sel_i  (div_sel_i),
    .wr_en_o    (wr_en),
    .wr_ch_o    (wr_ch),
    .wr_val_o   (wr_val)
  );

  tpm_value_bank #(.NCH(NCH), .CW(CW), .CHW(CHW)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (meas_en_i),
    .wr_en_i  (wr_en),
    .wr_ch_i  (wr_ch),
    .wr_val_i (wr_val),
    .limit_i  (limit_i),
    .count_o  (count_o),
    .over_o   (over_limit_o)
  );

endmodule

// File: tb/tach_period_meter_bench.sv
module tach_period_meter_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  tach;
  logic        ref_tick;
  logic [7:0]  en;
  logic [15:0] dsel;
  logic [63:0] lim;
  logic [63:0] cnt;
  logic [7:0]  ovl;

  int half [NCH];
  int pc   [NCH];
  int nchk = 0;
  int nfail = 0;
  int prev_max = 0;
  bit finished = 1'b0;
  bit ph;

  always #(CLK_PERIOD/2) clk = ~clk;

  tach_period_meter u_tach_period_meter (
    .clk          (clk),
    .rst_n        (rst_n),
    .tach_i       (tach),
    .ref_tick_i   (ref_tick),
    .meas_en_i    (en),
    .div_sel_i    (dsel),
    .limit_i      (lim),
    .count_o      (cnt),
    .over_limit_o (ovl)
  );

  // ticks on even cycles, tach changes on odd cycles: edges never share a cycle with a tick
  always @(negedge clk) begin
    if (!rst_n) begin
      ph = 1'b0;
      ref_tick = 1'b0;
      tach = '0;
      for (int k = 0; k < NCH; k++) pc[k] = 0;
    end else if (!ph) begin
      ref_tick = 1'b1;
      ph = 1'b1;
    end else begin
      ref_tick = 1'b0;
      ph = 1'b0;
      for (int k = 0; k < NCH; k++) begin
        if (half[k] != 0) begin
          if (pc[k] >= half[k] - 1) begin
            pc[k] = 0;
            tach[k] = ~tach[k];
          end else begin
            pc[k] = pc[k] + 1;
          end
        end
      end
    end
  end

  function automatic int exp_cnt(input int h, input int sel);
    int v;
    if (h == 0) return 255;
    v = (4 * h) / (1 << sel);
    return (v > 255) ? 255 : v;
  endfunction

  function automatic int exp_flag(input int e, input int v, input int l);
    if (e == 0) return 0;
    return (v > l || v == 255) ? 1 : 0;
  endfunction

  function automatic int bound_slots(input int h, input int sel);
    if (h == 0) return 255 * (1 << sel) + 4;
    return 6 * h + 8 + 255 * ((sel == 0) ? 1 : 0);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    int sum;
    int mx;
    sum = 0;
    mx = 0;
    for (int k = 0; k < NCH; k++) begin
      if (en[k]) begin
        int b;
        b = bound_slots(half[k], int'(dsel[2*k +: 2]));
        sum += b;
        if (b > mx) mx = b;
      end
    end
    if (mx > prev_max) prev_max = mx;
    cycles(2 * (2 * sum + prev_max) + 100);
    prev_max = mx;
  endtask

  task automatic check_all(input string req);
    for (int k = 0; k < NCH; k++) begin
      int v;
      v = en[k] ? exp_cnt(half[k], int'(dsel[2*k +: 2])) : 0;
      check({req, " count"}, int'(cnt[8*k +: 8]), v);
      check({req, " flag"}, int'(ovl[k]), exp_flag(int'(en[k]), v, int'(lim[8*k +: 8])));
    end
  endtask

  initial begin
    for (int k = 0; k < NCH; k++) half[k] = 0;
    rst_n = 1'b0;
    en = '0;
    dsel = '0;
    lim = '0;
    cycles(5);
    // R1 during reset
    check("R1 counts in reset", int'(cnt != 64'd0), 0);
    check("R1 flags in reset", int'(ovl), 0);
    rst_n = 1'b1;
    cycles(20);
    check("R1 counts after reset", int'(cnt != 64'd0), 0);
    check("R1 flags after reset", int'(ovl), 0);

    // R2 basic window on channel 0
    en = 8'h01;
    half[0] = 10;
    lim[7:0] = 8'd40;
    settle();
    check("R2 ch0 count H10 div1", int'(cnt[7:0]), 40);
    check("R6 equal limit no flag", int'(ovl[0]), 0);
    lim[7:0] = 8'd39;
    #1;
    check("R6 below count flags", int'(ovl[0]), 1);

    // R3 divisor encodings
    for (int s = 1; s < 4; s++) begin
      dsel[1:0] = 2'(s);
      settle();
      check("R3 divisor select", int'(cnt[7:0]), 40 >> s);
    end

    // R4 saturation inside the window
    dsel[1:0] = 2'd0;
    half[0] = 100;
    lim[7:0] = 8'd255;
    settle();
    check("R4 saturated count", int'(cnt[7:0]), 255);
    check("R4 saturated flag", int'(ovl[0]), 1);

    // R5 stalled ch3 next to running ch6 (R8)
    en = 8'h48;
    half[3] = 0;
    dsel[7:6] = 2'd1;
    half[6] = 20;
    dsel[13:12] = 2'd0;
    lim[55:48] = 8'd100;
    settle();
    check("R5 stalled ch3", int'(cnt[31:24]), 255);
    check("R5 stalled ch3 flag", int'(ovl[3]), 1);
    check("R8 ch6 alongside stall", int'(cnt[55:48]), 80);
    check("R7 disabled ch0 count", int'(cnt[7:0]), 0);
    check("R7 disabled ch0 flag", int'(ovl[0]), 0);

    // R7 disable mid-run
    en = 8'h08;
    cycles(2);
    check("R7 ch6 cleared", int'(cnt[55:48]), 0);
    check("R7 ch6 flag cleared", int'(ovl[6]), 0);

    // random rounds (R2 R3 R6 R8)
    void'($urandom(32'd1234));
    for (int r = 0; r < 3; r++) begin
      en = 8'($urandom);
      if (en == 8'h00) en = 8'h81;
      for (int k = 0; k < NCH; k++) begin
        half[k] = ($urandom % 8 == 0) ? 0 : 3 + int'($urandom % 118);
        dsel[2*k +: 2] = 2'($urandom);
        lim[8*k +: 8] = 8'($urandom);
      end
      settle();
      check_all("R8 random round");
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    finished = 1'b1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 195000);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL R8 watchdog expired: actual running expected done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule